// File: doc/BRIEF.md
# Bi-phase Lighting Bus Frame Transmitter

This block sends one lighting-control frame onto a single-bit line using bi-phase coding. Each bit lasts two half-bit periods (TE). A one is sent as a low half followed by a high half. A zero is sent as a high half followed by a low half. A one-cycle start request captures the frame kind and the payload. The payload is a 16-bit word for a command frame from the controller, or its low byte for a reply frame from a lamp unit. The block expands the payload into a half-bit stream and drives that stream out at one half-bit per TE. TE is counted from the system clock by a parameterized divider; with the default of 16000 clocks it is about 417 µs at 38.4 MHz.

Every stream starts with idle-level padding so that its length is a whole number of bytes. Command frames get 26 padding half-bits (64 in total). The extra padding provides the minimum quiet gap that must come before such a frame. Reply frames get 2 padding half-bits (24 in total). After the padding come a start bit of one, the payload bits with the most significant bit first, and four half-bits of idle level as the stop period.

A polarity input sets whether the bus rests high or low, so an inverting isolator can be used. When the bus rests low, the whole output is inverted.

Top module: `dali_manch_tx`

## Requirements
- R1: After reset, busy_o and done_o are low and line_o equals idle_hi_i.
- R2: With fwd_i = 0 (reply frame), the stream is 24 half-bits long. It is 2 idle half-bits, then the start pair low-high, then word_i[7:0] from bit 7 down, then 4 idle half-bits. In the stream a one becomes the pair low-high and a zero becomes high-low. For payload 0x64 the stream, read in time order, is the bytes 0xD9, 0x69, 0xAF.
- R3: With fwd_i = 1 (command frame), the stream is 64 half-bits long. It is 26 idle half-bits, then the start pair, then word_i[15:0] from bit 15 down (address byte first), then 4 idle half-bits.
- R4: Each half-bit is held on line_o for exactly CLK_PER_TE clock cycles. The first half-bit appears in the cycle after the clock edge that accepts the start.
- R5: busy_o rises in the cycle after an accepted start and stays high until the last half-bit has been held for its full time.
- R6: done_o is high for exactly one cycle, which is the first cycle with busy_o low after a frame.
- R7: A start while busy_o is high is ignored. The frame in progress, its payload and its timing do not change.
- R8: With idle_hi_i = 1, stream bits are driven as they are. With idle_hi_i = 0, every driven level is inverted. When not busy, line_o equals idle_hi_i.
- R9: The polarity is captured at start. A change of idle_hi_i during a frame has no effect until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send a frame; accepted only when idle |
| fwd_i | input | 1 | Frame kind: 1 = command (16-bit), 0 = reply (8-bit) |
| word_i | input | 16 | Payload; a reply frame uses bits 7:0 |
| idle_hi_i | input | 1 | 1 = bus rests high, 0 = bus rests low (output inverted) |
| line_o | output | 1 | Coded bus output |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the final half-bit |

## Verification
The assertions assume that start_i, fwd_i, word_i and idle_hi_i change only between clock edges. They also assume that reset is held for at least one edge before any start. The bench drives every input on the falling clock edge and holds reset for several cycles before the first request. The level-hold property assumes that polarity changes during a frame are masked by the captured value. The bench toggles idle_hi_i in the middle of frames and pulses start_i inside frames with different payloads and kinds, so both masking paths are exercised rather than assumed.

// File: rtl/dali_tx_pkg.sv
package dali_tx_pkg;

    typedef enum logic {
        FRAME_REPLY   = 1'b0,
        FRAME_COMMAND = 1'b1
    } frame_kind_e;

    localparam int CMD_BITS    = 16;
    localparam int REPLY_BITS  = 8;
    localparam int STOP_HALVES = 4;
    localparam int CMD_PAD     = 26;
    localparam int REPLY_PAD   = 2;
    localparam int CMD_LEN     = CMD_PAD + 2 + 2 * CMD_BITS + STOP_HALVES;
    localparam int REPLY_LEN   = REPLY_PAD + 2 + 2 * REPLY_BITS + STOP_HALVES;
    localparam int STREAM_W    = CMD_LEN;
    localparam int LEN_W       = $clog2(STREAM_W + 1);

    // start bit is a logical one: low half then high half
    localparam logic [1:0] START_PAIR = 2'b01;

    function automatic logic [1:0] half_pair(input logic b);
        return {~b, b};
    endfunction

    typedef struct packed {
        logic [STREAM_W-1:0] bits;
        logic [LEN_W-1:0]    len;
    } halfbit_frame_t;

endpackage

// File: rtl/dali_te_timer.sv
module dali_te_timer #(
    parameter int CLK_PER_TE = 16000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_TE > 1) ? $clog2(CLK_PER_TE) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TE - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dali_frame_builder.sv
module dali_frame_builder
    import dali_tx_pkg::*;
(
    input  frame_kind_e    kind_i,
    input  logic [15:0]    word_i,
    output halfbit_frame_t frame_o
);
    logic [2*CMD_BITS-1:0] enc;

    for (genvar g = 0; g < CMD_BITS; g++) begin : g_enc
        assign enc[2*g+1 -: 2] = half_pair(word_i[g]);
    end

    always_comb begin
        if (kind_i == FRAME_COMMAND) begin
            frame_o.bits = {{CMD_PAD{1'b1}}, START_PAIR, enc,
                            {STOP_HALVES{1'b1}}};
            frame_o.len  = LEN_W'(CMD_LEN);
        end else begin
            frame_o.bits = {{REPLY_PAD{1'b1}}, START_PAIR,
                            enc[2*REPLY_BITS-1:0], {STOP_HALVES{1'b1}},
                            {(STREAM_W - REPLY_LEN){1'b0}}};
            frame_o.len  = LEN_W'(REPLY_LEN);
        end
    end
endmodule

// File: rtl/dali_halfbit_shifter.sv
module dali_halfbit_shifter
    import dali_tx_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           load_i,
    input  halfbit_frame_t frame_i,
    input  logic           pol_i,
    input  logic           tick_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           level_o
);
    logic [STREAM_W-1:0] sr_q;
    logic [LEN_W-1:0]    left_q;
    logic                busy_q;
    logic                done_q;
    logic                pol_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sr_q   <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            pol_q  <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (load_i && !busy_q) begin
                sr_q   <= frame_i.bits;
                left_q <= frame_i.len;
                busy_q <= 1'b1;
                pol_q  <= pol_i;
            end else if (busy_q && tick_i) begin
                sr_q   <= {sr_q[STREAM_W-2:0], 1'b1};
                left_q <= left_q - 1'b1;
                if (left_q == LEN_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // low idle: invert the whole stream
    assign level_o = sr_q[STREAM_W-1] ^ ~pol_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;
endmodule

// File: rtl/dali_manch_tx.sv
module dali_manch_tx
    import dali_tx_pkg::*;
#(
    parameter int CLK_PER_TE = 16000
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        start_i,
    input  logic        fwd_i,
    input  logic [15:0] word_i,
    input  logic        idle_hi_i,
    output logic        line_o,
    output logic        busy_o,
    output logic        done_o
);
    halfbit_frame_t frame;
    frame_kind_e    kind;
    logic           te_tick;
    logic           busy;
    logic           level;
    logic           accept;

    assign kind   = frame_kind_e'(fwd_i);
    assign accept = start_i && !busy;

    dali_frame_builder u_build (
        .kind_i  (kind),
        .word_i  (word_i),
        .frame_o (frame)
    );

    dali_te_timer #(.CLK_PER_TE(CLK_PER_TE)) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (accept),
        .run_i   (busy),
        .tick_o  (te_tick)
    );

    dali_halfbit_shifter u_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (accept),
        .frame_i (frame),
        .pol_i   (idle_hi_i),
        .tick_i  (te_tick),
        .busy_o  (busy),
        .done_o  (done_o),
        .level_o (level)
    );

    assign busy_o = busy;
    assign line_o = busy ? level : idle_hi_i;
endmodule

// File: rtl/dali_manch_tx_chk.sv
module dali_manch_tx_chk (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic idle_hi_i,
    input logic line_o,
    input logic busy_o,
    input logic done_o,
    input logic te_tick
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o); // R6
    AST_DONE_AT_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!busy_o && $past(busy_o))); // R6
    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (line_o == idle_hi_i)); // R8
    AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> $past(start_i)); // R5
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && $past(busy_o) && !$past(te_tick)) |-> $stable(line_o)); // R4
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && start_i) |=> (busy_o || done_o)); // R7
endmodule

bind dali_manch_tx dali_manch_tx_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .idle_hi_i (idle_hi_i),
    .line_o    (line_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .te_tick   (te_tick)
);

// File: tb/tb_dali_manch_tx.sv
module tb_dali_manch_tx;
    localparam int TE = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        fwd_i;
    logic [15:0] word_i;
    logic        idle_hi_i;
    logic        line_o, busy_o, done_o;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [63:0] cap;

    always #2 clk = ~clk;

    dali_manch_tx #(.CLK_PER_TE(TE)) dut (
        .clk_i(clk), .rst_i(rst), .start_i(start_i), .fwd_i(fwd_i),
        .word_i(word_i), .idle_hi_i(idle_hi_i),
        .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected half-bit stream, time order from bit 63 down
    task automatic expect_stream(input logic fwd, input logic [15:0] w,
                                 output logic [63:0] s, output int n);
        int pad   = fwd ? 26 : 2;
        int nbits = fwd ? 16 : 8;
        int p = 63;
        s = '0;
        for (int i = 0; i < pad; i++) begin s[p] = 1'b1; p--; end
        s[p] = 1'b0; p--; s[p] = 1'b1; p--;
        for (int i = nbits - 1; i >= 0; i--) begin
            s[p] = ~w[i]; p--; s[p] = w[i]; p--;
        end
        for (int i = 0; i < 4; i++) begin s[p] = 1'b1; p--; end
        n = 63 - p;
    endtask

    // inj: half-bit index at which a stray start is pulsed (-1 none)
    // flp: half-bit index at which idle_hi_i is toggled (-1 none)
    task automatic run_frame(input logic fwd, input logic [15:0] w,
                             input logic pol, input int inj, input int flp);
        logic [63:0] s;
        int n;
        expect_stream(fwd, w, s, n);
        fwd_i = fwd; word_i = w; idle_hi_i = pol; start_i = 1'b1;
        cap = '0;
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < TE; j++) begin
                @(negedge clk);
                if (k == 0 && j == 0) start_i = 1'b0;
                if (k == inj && j == 0) begin
                    start_i = 1'b1; fwd_i = ~fwd; word_i = ~w;
                end
                if (k == inj && j == 1) start_i = 1'b0;
                if (k == flp && j == 0) idle_hi_i = ~pol;
                // R4 R2 R3 R8 R9 R7: level held for TE cycles, latched polarity
                check({31'd0, line_o}, {31'd0, s[63-k] ^ ~pol},
                      fwd ? "R3 line" : "R2 line");
                check({31'd0, busy_o}, 32'd1, "R5 busy");
                check({31'd0, done_o}, 32'd0, "R6 done early");
                if (j == TE / 2) cap = {cap[62:0], line_o ^ ~pol};
            end
        end
        @(negedge clk);
        check({31'd0, busy_o}, 32'd0, "R5 busy end");
        check({31'd0, done_o}, 32'd1, "R6 done");
        check({31'd0, line_o}, {31'd0, idle_hi_i}, "R8 idle after");
        @(negedge clk);
        check({31'd0, done_o}, 32'd0, "R6 done width");
        idle_hi_i = pol;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; fwd_i = 1'b0; word_i = '0; idle_hi_i = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({31'd0, busy_o}, 32'd0, "R1 busy");
        check({31'd0, done_o}, 32'd0, "R1 done");
        check({31'd0, line_o}, 32'd1, "R1 line high");
        idle_hi_i = 1'b0;
        @(negedge clk);
        check({31'd0, line_o}, 32'd0, "R1 R8 line low");

        // R2 known reply pattern
        run_frame(1'b0, 16'h0064, 1'b1, -1, -1);
        check(cap[23:0], 32'h00D969AF, "R2 bytes 0x64");

        // R2 R8 all reply bytes, both polarities
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < 256; b++)
                run_frame(1'b0, 16'(b), p[0], -1, -1);

        // R3 R8 command words, both polarities
        for (int p = 0; p < 2; p++) begin
            run_frame(1'b1, 16'h0000, p[0], -1, -1);
            run_frame(1'b1, 16'hFFFF, p[0], -1, -1);
            run_frame(1'b1, 16'hFF90, p[0], -1, -1);
            for (int k = 0; k < 48; k++)
                run_frame(1'b1, 16'((k * 16'h0503) ^ 16'hA55A), p[0], -1, -1);
        end

        // R7 stray starts mid-frame
        run_frame(1'b0, 16'h00C3, 1'b1, 5, -1);
        run_frame(1'b1, 16'h1234, 1'b0, 30, -1);
        run_frame(1'b1, 16'h8001, 1'b1, 63, -1);

        // R9 polarity toggled mid-frame
        run_frame(1'b0, 16'h005A, 1'b1, -1, 3);
        run_frame(1'b1, 16'hBEEF, 1'b0, -1, 40);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule